// File: doc/BRIEF.md
# Masked-Page Translation Buffer

This block is a small fully associative translation buffer. Each slot covers a pair of adjacent pages, even and odd, with one virtual page number, one page mask, an 8-bit address-space tag and a shared global flag. Each half of the pair has its own physical frame number, a 3-bit cache attribute, a dirty bit and a valid bit. Matching compares only the page-number bits that the slot's own mask leaves clear. The address-space compare is skipped for global slots.

Two matching ports run side by side over the registered table, and both are combinational. The lookup port returns a hit flag and both frame words of the winning slot. The probe port returns the winning slot's index, or all ones on a miss. Slots are filled through a single-cycle indexed write port that takes the same packed words the read-back port produces. A flush input clears the whole table. A replacement pointer steps through the slots whenever software asks it to advance.

Top module: `tlbm_top`

## Requirements
- R1: A slot matches a request page number when the two agree on every bit where the slot's mask is 0. Bits set in the mask are not compared.
- R2: A match also needs the slot's global flag set or the request tag equal to the slot's tag. On a write, the stored global flag is the AND of bit 0 of the two frame words.
- R3: A slot takes part in matching only while at least one of its two valid bits is 1. A slot of all zeros never matches, even for page 0 and tag 0.
- R4: When several slots match, both the lookup and the probe report the lowest-numbered one.
- R5: The probe output is the matching index (width log2(ENTRIES)+1). On a miss it is all ones. On a lookup miss the hit flag and both frame words are 0.
- R6: A write whose index is ENTRIES or above changes no slot.
- R7: Packed formats, used for both write and read-back. Frame word = {pfn, cattr[2:0], dirty, valid, global}, so cattr sits at bits 5:3, dirty at 2, valid at 1 and global at 0. High word = page number shifted left by 11, with the tag in bits 7:0 and bits 10:8 zero. Mask word = mask shifted left by 11.
- R8: A write is seen on every port from the cycle after its clock edge. Overwriting a slot removes its old page number from matching.
- R9: Flush sets every slot to zero and the replacement pointer to 0 at the next edge. It takes priority over a write and an advance in the same cycle.
- R10: Each advance moves the replacement pointer up by one, from ENTRIES-1 back to 0. Without an advance the pointer holds.
- R11: After reset every slot reads as zero and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_lo0 | output | PFN_W+6 | Even-page frame word of the matching slot |
| lk_lo1 | output | PFN_W+6 | Odd-page frame word of the matching slot |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | 8 | Probe address-space tag |
| pr_idx | output | log2(ENTRIES)+1 | Index of the matching slot, all ones on a miss |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_IN_W | Slot to write |
| wr_hi | input | VPN_W+11 | High word to write |
| wr_mask | input | VPN_W+11 | Mask word to write |
| wr_lo0 | input | PFN_W+6 | Even-page frame word to write |
| wr_lo1 | input | PFN_W+6 | Odd-page frame word to write |
| rd_idx | input | log2(ENTRIES) | Slot to read back |
| rd_hi | output | VPN_W+11 | High word of the read slot |
| rd_mask | output | VPN_W+11 | Mask word of the read slot |
| rd_lo0 | output | PFN_W+6 | Even frame word of the read slot |
| rd_lo1 | output | PFN_W+6 | Odd frame word of the read slot |
| flush | input | 1 | Clear every slot and the pointer |
| adv | input | 1 | Advance the replacement pointer |
| victim | output | log2(ENTRIES) | Replacement pointer |

## Verification
The bench builds the block with ENTRIES=4, VPN_W=8, PFN_W=10 and IDX_IN_W=4. With four slots, the pointer wraps after four advances, so the wrap is reached quickly. A 4-bit write index can name slots 4 to 15, so out-of-range writes can be driven. Eight-bit page numbers allow a partly masked slot to be checked on both sides of its mask boundary. Several slots can also be made to hold the same page number, which exposes the lowest-index priority.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int ASID_W   = 8;
    localparam int HI_SHIFT = 11;
    localparam int LO_SHIFT = 6;
    localparam int CATTR_W  = 3;

    typedef logic [ASID_W-1:0] asid_t;

    typedef struct packed {
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } pg_attr_t;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_WRITE,
        UPD_FLUSH
    } upd_e;

    function automatic logic [LO_SHIFT-1:0] lo_meta(pg_attr_t a, logic g);
        return {a.cattr, a.dirty, a.valid, g};
    endfunction

endpackage

// File: rtl/tlbm_match.sv
module tlbm_match
    import tlbm_pkg::*;
#(
    parameter int VPN_W = 19
) (
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [VPN_W-1:0] ent_mask,
    input  asid_t            ent_asid,
    input  logic             ent_glob,
    input  logic             ent_live,
    input  logic [VPN_W-1:0] req_vpn,
    input  asid_t            req_asid,
    output logic             hit
);
    logic vpn_eq;
    logic asid_ok;

    always_comb begin
        vpn_eq  = ((req_vpn ^ ent_vpn) & ~ent_mask) == '0;
        asid_ok = ent_glob || (req_asid == ent_asid);
        hit     = ent_live && vpn_eq && asid_ok;
    end
endmodule

// File: rtl/tlbm_first.sv
module tlbm_first #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbm_victim.sv
module tlbm_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlbm_top.sv
module tlbm_top
    import tlbm_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int VPN_W    = 19,
    parameter int PFN_W    = 20,
    parameter int IDX_IN_W = 4,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int PR_W    = IDX_W + 1,
    localparam int HI_W    = VPN_W + HI_SHIFT,
    localparam int LO_W    = PFN_W + LO_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [ASID_W-1:0]   lk_asid,
    output logic                lk_hit,
    output logic [LO_W-1:0]     lk_lo0,
    output logic [LO_W-1:0]     lk_lo1,
    input  logic [VPN_W-1:0]    pr_vpn,
    input  logic [ASID_W-1:0]   pr_asid,
    output logic [PR_W-1:0]     pr_idx,
    input  logic                wr_en,
    input  logic [IDX_IN_W-1:0] wr_idx,
    input  logic [HI_W-1:0]     wr_hi,
    input  logic [HI_W-1:0]     wr_mask,
    input  logic [LO_W-1:0]     wr_lo0,
    input  logic [LO_W-1:0]     wr_lo1,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [HI_W-1:0]     rd_hi,
    output logic [HI_W-1:0]     rd_mask,
    output logic [LO_W-1:0]     rd_lo0,
    output logic [LO_W-1:0]     rd_lo1,
    input  logic                flush,
    input  logic                adv,
    output logic [IDX_W-1:0]    victim
);
    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] mask;
        asid_t            asid;
        logic             glob;
        logic [PFN_W-1:0] pfn0;
        pg_attr_t         a0;
        logic [PFN_W-1:0] pfn1;
        pg_attr_t         a1;
    } ent_t;

    function automatic logic [LO_W-1:0] pk_lo(logic [PFN_W-1:0] p, pg_attr_t a, logic g);
        return {p, lo_meta(a, g)};
    endfunction

    function automatic logic [HI_W-1:0] pk_hi(ent_t e);
        return {e.vpn, {(HI_SHIFT - ASID_W){1'b0}}, e.asid};
    endfunction

    ent_t         tab [ENTRIES];
    ent_t         new_ent;
    upd_e         upd;
    logic [ENTRIES-1:0] lk_req;
    logic [ENTRIES-1:0] pr_req;
    logic         lk_found;
    logic         pr_found;
    logic [IDX_W-1:0] lk_sel;
    logic [IDX_W-1:0] pr_sel;
    ent_t         lk_e;
    ent_t         rd_e;
    logic         unused_fields;

    assign unused_fields = ^{wr_hi[HI_SHIFT-1:ASID_W], wr_mask[HI_SHIFT-1:0]};

    // decode of the packed write words
    always_comb begin
        new_ent.vpn  = wr_hi[HI_W-1:HI_SHIFT];
        new_ent.asid = wr_hi[ASID_W-1:0];
        new_ent.mask = wr_mask[HI_W-1:HI_SHIFT];
        new_ent.glob = wr_lo0[0] & wr_lo1[0];
        new_ent.pfn0 = wr_lo0[LO_W-1:LO_SHIFT];
        new_ent.a0   = pg_attr_t'(wr_lo0[LO_SHIFT-1:1]);
        new_ent.pfn1 = wr_lo1[LO_W-1:LO_SHIFT];
        new_ent.a1   = pg_attr_t'(wr_lo1[LO_SHIFT-1:1]);
    end

    always_comb begin
        if (flush)      upd = UPD_FLUSH;
        else if (wr_en) upd = UPD_WRITE;
        else            upd = UPD_NONE;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst || upd == UPD_FLUSH) begin
                tab[i] <= '0;
            end else if (upd == UPD_WRITE && wr_idx == IDX_IN_W'(i)) begin
                tab[i] <= new_ent;
            end
        end
    end

    // per-slot comparators for both ports
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic live;
        assign live = tab[g].a0.valid | tab[g].a1.valid;

        tlbm_match #(.VPN_W(VPN_W)) u_lk (
            .ent_vpn (tab[g].vpn),
            .ent_mask(tab[g].mask),
            .ent_asid(tab[g].asid),
            .ent_glob(tab[g].glob),
            .ent_live(live),
            .req_vpn (lk_vpn),
            .req_asid(lk_asid),
            .hit     (lk_req[g])
        );

        tlbm_match #(.VPN_W(VPN_W)) u_pr (
            .ent_vpn (tab[g].vpn),
            .ent_mask(tab[g].mask),
            .ent_asid(tab[g].asid),
            .ent_glob(tab[g].glob),
            .ent_live(live),
            .req_vpn (pr_vpn),
            .req_asid(pr_asid),
            .hit     (pr_req[g])
        );
    end

    tlbm_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_first (
        .req  (lk_req),
        .found(lk_found),
        .idx  (lk_sel)
    );

    tlbm_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_pr_first (
        .req  (pr_req),
        .found(pr_found),
        .idx  (pr_sel)
    );

    always_comb begin
        lk_e   = lk_found ? tab[lk_sel] : '0;
        lk_hit = lk_found;
        lk_lo0 = pk_lo(lk_e.pfn0, lk_e.a0, lk_e.glob);
        lk_lo1 = pk_lo(lk_e.pfn1, lk_e.a1, lk_e.glob);
        pr_idx = pr_found ? {1'b0, pr_sel} : '1;
    end

    always_comb begin
        rd_e    = (int'(rd_idx) < ENTRIES) ? tab[rd_idx] : '0;
        rd_hi   = pk_hi(rd_e);
        rd_mask = {rd_e.mask, {HI_SHIFT{1'b0}}};
        rd_lo0  = pk_lo(rd_e.pfn0, rd_e.a0, rd_e.glob);
        rd_lo1  = pk_lo(rd_e.pfn1, rd_e.a1, rd_e.glob);
    end

    tlbm_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk  (clk),
        .rst  (rst),
        .flush(flush),
        .adv  (adv),
        .ptr  (victim)
    );
endmodule

// File: rtl/tlbm_chk.sv
module tlbm_chk #(
    parameter int ENTRIES  = 8,
    parameter int IDX_W    = 3,
    parameter int PR_W     = 4,
    parameter int VPN_W    = 19,
    parameter int HI_W     = 30,
    parameter int LO_W     = 26,
    parameter int IDX_IN_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic                adv,
    input logic [IDX_W-1:0]    victim,
    input logic                wr_en,
    input logic [IDX_IN_W-1:0] wr_idx,
    input logic [IDX_W-1:0]    rd_idx,
    input logic [HI_W-1:0]     rd_hi,
    input logic [LO_W-1:0]     rd_lo0,
    input logic [LO_W-1:0]     rd_lo1,
    input logic [VPN_W-1:0]    lk_vpn,
    input logic [7:0]          lk_asid,
    input logic [VPN_W-1:0]    pr_vpn,
    input logic [7:0]          pr_asid,
    input logic                lk_hit,
    input logic                lk_v0,
    input logic                lk_v1,
    input logic [PR_W-1:0]     pr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R10
    victim_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(victim) < ENTRIES);

    // R10
    victim_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !flush) |=> victim == (($past(victim) == LAST) ? '0 : $past(victim) + 1'b1));

    // R10
    victim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !flush) |=> $stable(victim));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (victim == '0 && rd_hi == '0 && rd_lo0 == '0 && rd_lo1 == '0 && !lk_hit && pr_idx == '1));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (victim == '0 && pr_idx == '1 && !lk_hit));

    // R3
    hit_live_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_v0 || lk_v1));

    // R5
    probe_code_chk: assert property (@(posedge clk) disable iff (rst)
        (pr_idx == '1) || (int'(pr_idx) < ENTRIES));

    // R4
    port_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_vpn == pr_vpn && lk_asid == pr_asid) |-> (lk_hit == (pr_idx != '1)));

    // R6
    oob_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush && int'(wr_idx) >= ENTRIES) |=>
        (!$stable(rd_idx) || ($stable(rd_hi) && $stable(rd_lo0) && $stable(rd_lo1))));
endmodule

bind tlbm_top tlbm_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .PR_W    (PR_W),
    .VPN_W   (VPN_W),
    .HI_W    (HI_W),
    .LO_W    (LO_W),
    .IDX_IN_W(IDX_IN_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .adv    (adv),
    .victim (victim),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .rd_hi  (rd_hi),
    .rd_lo0 (rd_lo0),
    .rd_lo1 (rd_lo1),
    .lk_vpn (lk_vpn),
    .lk_asid(lk_asid),
    .pr_vpn (pr_vpn),
    .pr_asid(pr_asid),
    .lk_hit (lk_hit),
    .lk_v0  (lk_lo0[1]),
    .lk_v1  (lk_lo1[1]),
    .pr_idx (pr_idx)
);

// File: tb/sim_tlbm_top.sv
module sim_tlbm_top;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 4;
    localparam int VPN_W      = 8;
    localparam int PFN_W      = 10;
    localparam int IDX_IN_W   = 4;
    localparam int IDX_W      = 2;
    localparam int PR_W       = 3;
    localparam int HI_W       = VPN_W + 11;
    localparam int LO_W       = PFN_W + 6;

    typedef enum int {K_HIT, K_LO0, K_LO1, K_PR, K_VIC, K_RHI, K_RMASK, K_RLO0, K_RLO1} kind_e;

    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [VPN_W-1:0]    lk_vpn = '0;
    logic [7:0]          lk_asid = '0;
    logic                lk_hit;
    logic [LO_W-1:0]     lk_lo0, lk_lo1;
    logic [VPN_W-1:0]    pr_vpn = '0;
    logic [7:0]          pr_asid = '0;
    logic [PR_W-1:0]     pr_idx;
    logic                wr_en = 1'b0;
    logic [IDX_IN_W-1:0] wr_idx = '0;
    logic [HI_W-1:0]     wr_hi = '0;
    logic [HI_W-1:0]     wr_mask = '0;
    logic [LO_W-1:0]     wr_lo0 = '0;
    logic [LO_W-1:0]     wr_lo1 = '0;
    logic [IDX_W-1:0]    rd_idx = '0;
    logic [HI_W-1:0]     rd_hi, rd_mask;
    logic [LO_W-1:0]     rd_lo0, rd_lo1;
    logic                flush = 1'b0;
    logic                adv = 1'b0;
    logic [IDX_W-1:0]    victim;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];
    event  chk_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlbm_top #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_IN_W(IDX_IN_W)) u0 (
        .clk(clk), .rst(rst),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_lo0(lk_lo0), .lk_lo1(lk_lo1),
        .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_idx(pr_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_mask(wr_mask),
        .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
        .flush(flush), .adv(adv), .victim(victim)
    );

    function automatic logic [31:0] observed(kind_e k);
        case (k)
            K_HIT:   return 32'(lk_hit);
            K_LO0:   return 32'(lk_lo0);
            K_LO1:   return 32'(lk_lo1);
            K_PR:    return 32'(pr_idx);
            K_VIC:   return 32'(victim);
            K_RHI:   return 32'(rd_hi);
            K_RMASK: return 32'(rd_mask);
            K_RLO0:  return 32'(rd_lo0);
            default: return 32'(rd_lo1);
        endcase
    endfunction

    // monitor: pops expected items and compares them with the outputs
    always @(chk_ev) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = sb_q.pop_front();
            got = observed(it.kind);
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%s actual=%h expected=%h", it.req, it.kind.name(), got, it.exp);
            end
        end
    end

    function automatic logic [LO_W-1:0] mk_lo(logic [PFN_W-1:0] p, logic [2:0] c, logic d, logic v, logic g);
        return {p, c, d, v, g};
    endfunction

    task automatic push(kind_e k, logic [31:0] e, string r);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.req  = r;
        sb_q.push_back(it);
    endtask

    task automatic fire();
        #1 -> chk_ev;
        #1;
    endtask

    task automatic wr(logic [IDX_IN_W-1:0] idx, logic [VPN_W-1:0] vpn, logic [VPN_W-1:0] msk,
                      logic [7:0] asid, logic [LO_W-1:0] l0, logic [LO_W-1:0] l1);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = idx;
        wr_hi   = {vpn, 3'b000, asid};
        wr_mask = {msk, 11'b0};
        wr_lo0  = l0;
        wr_lo1  = l1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic look(logic [VPN_W-1:0] vpn, logic [7:0] asid, logic hit,
                        logic [31:0] lo0, logic [PR_W-1:0] pidx, string r);
        @(negedge clk);
        lk_vpn  = vpn;
        lk_asid = asid;
        pr_vpn  = vpn;
        pr_asid = asid;
        push(K_HIT, 32'(hit), r);
        push(K_LO0, lo0, r);
        push(K_PR, 32'(pidx), r);
        fire();
    endtask

    task automatic rdchk(logic [IDX_W-1:0] idx, logic [31:0] hi, logic [31:0] msk,
                         logic [31:0] l0, logic [31:0] l1, string r);
        @(negedge clk);
        rd_idx = idx;
        push(K_RHI, hi, r);
        push(K_RMASK, msk, r);
        push(K_RLO0, l0, r);
        push(K_RLO1, l1, r);
        fire();
    endtask

    task automatic step_adv(logic [31:0] exp_v, string r);
        @(negedge clk);
        adv = 1'b1;
        @(posedge clk);
        #1 adv = 1'b0;
        push(K_VIC, exp_v, r);
        fire();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11: reset state
        push(K_VIC, 32'd0, "R11");
        fire();
        for (int i = 0; i < ENTRIES; i++) rdchk(IDX_W'(i), 0, 0, 0, 0, "R11");
        // R3: zeroed slots do not match page 0 / tag 0
        look(8'h00, 8'h00, 1'b0, 0, 3'b111, "R3");

        // R7: packed write and read-back
        wr(4'd1, 8'h12, 8'h00, 8'h05, mk_lo(10'h101, 3'd3, 1'b1, 1'b1, 1'b0),
           mk_lo(10'h102, 3'd2, 1'b0, 1'b1, 1'b0));
        rdchk(2'd1, 32'h9005, 32'h0, 32'h405E, 32'h4092, "R7");
        // R8 / R5: visible right after the write edge
        look(8'h12, 8'h05, 1'b1, 32'h405E, 3'd1, "R8");
        push(K_LO1, 32'h4092, "R8");
        fire();
        // R2: tag mismatch on a non-global slot
        look(8'h12, 8'h06, 1'b0, 0, 3'b111, "R2");

        // R1: masked slot, global
        wr(4'd2, 8'h30, 8'h0F, 8'h09, mk_lo(10'h0AA, 3'd0, 1'b0, 1'b1, 1'b1),
           mk_lo(10'h000, 3'd0, 1'b0, 1'b0, 1'b1));
        rdchk(2'd2, 32'h18009, 32'h7800, 32'h2A83, 32'h0001, "R7");
        look(8'h3C, 8'd77, 1'b1, 32'h2A83, 3'd2, "R1");
        look(8'h40, 8'h09, 1'b0, 0, 3'b111, "R1");

        // R2: global flag is the AND of both frame words
        wr(4'd3, 8'h50, 8'h00, 8'h01, mk_lo(10'h055, 3'd1, 1'b0, 1'b1, 1'b1),
           mk_lo(10'h000, 3'd0, 1'b0, 1'b0, 1'b0));
        rdchk(2'd3, 32'h28001, 32'h0, 32'h154A, 32'h0, "R2");
        look(8'h50, 8'h02, 1'b0, 0, 3'b111, "R2");
        look(8'h50, 8'h01, 1'b1, 32'h154A, 3'd3, "R2");

        // R4: two slots hold the same page, the lower one wins
        wr(4'd0, 8'h12, 8'h00, 8'h05, mk_lo(10'h3FF, 3'd0, 1'b0, 1'b1, 1'b0), '0);
        look(8'h12, 8'h05, 1'b1, 32'hFFC2, 3'd0, "R4");

        // R3: slot 0 with both valid bits clear drops out
        wr(4'd0, 8'h12, 8'h00, 8'h05, '0, '0);
        look(8'h12, 8'h05, 1'b1, 32'h405E, 3'd1, "R3");

        // R8: overwrite removes the old page
        wr(4'd1, 8'h13, 8'h00, 8'h05, mk_lo(10'h011, 3'd0, 1'b0, 1'b1, 1'b0), '0);
        look(8'h12, 8'h05, 1'b0, 0, 3'b111, "R8");
        look(8'h13, 8'h05, 1'b1, 32'h0442, 3'd1, "R8");

        // R6: out-of-range writes change nothing
        wr(4'd4, 8'h77, 8'h00, 8'h05, mk_lo(10'h077, 3'd0, 1'b0, 1'b1, 1'b0), '0);
        wr(4'd15, 8'h78, 8'h00, 8'h05, mk_lo(10'h078, 3'd0, 1'b0, 1'b1, 1'b0), '0);
        look(8'h77, 8'h05, 1'b0, 0, 3'b111, "R6");
        look(8'h78, 8'h05, 1'b0, 0, 3'b111, "R6");
        rdchk(2'd0, 32'h9005, 32'h0, 32'h0, 32'h0, "R6");
        rdchk(2'd1, 32'h9805, 32'h0, 32'h0442, 32'h0, "R6");
        rdchk(2'd2, 32'h18009, 32'h7800, 32'h2A83, 32'h0001, "R6");
        rdchk(2'd3, 32'h28001, 32'h0, 32'h154A, 32'h0, "R6");

        // R10: pointer steps and wraps
        step_adv(32'd1, "R10");
        step_adv(32'd2, "R10");
        step_adv(32'd3, "R10");
        step_adv(32'd0, "R10");
        step_adv(32'd1, "R10");
        repeat (2) @(posedge clk);
        #1 push(K_VIC, 32'd1, "R10");
        fire();

        // R9: flush wins over a write and an advance in the same cycle
        @(negedge clk);
        flush   = 1'b1;
        adv     = 1'b1;
        wr_en   = 1'b1;
        wr_idx  = 4'd2;
        wr_hi   = {8'h66, 3'b000, 8'h02};
        wr_mask = '0;
        wr_lo0  = mk_lo(10'h066, 3'd0, 1'b0, 1'b1, 1'b0);
        wr_lo1  = '0;
        @(posedge clk);
        #1;
        flush = 1'b0;
        adv   = 1'b0;
        wr_en = 1'b0;
        push(K_VIC, 32'd0, "R9");
        fire();
        for (int i = 0; i < ENTRIES; i++) rdchk(IDX_W'(i), 0, 0, 0, 0, "R9");
        look(8'h66, 8'h02, 1'b0, 0, 3'b111, "R9");
        look(8'h30, 8'h09, 1'b0, 0, 3'b111, "R9");
        look(8'h00, 8'h00, 1'b0, 0, 3'b111, "R3");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule